// File: doc/BRIEF.md
# Flash status-poll completion checker

This block runs on the host side of a flash bank once a program or erase command has been issued. It reads one status byte at a time from a single address. Each byte is judged on two bits: the completion bit (the top bit of the byte) and the timeout bit (bit 5). The block stops when it reaches a verdict, gives a one-cycle done pulse and holds a pass/fail flag.

Polling begins with a start pulse. The start pulse carries the address to poll, the expected value of the completion bit for a program, and an erase flag. For an erase the expected value is always 1. The address must lie in the area being written:
- the programmed location, for a program;
- any location inside a sector being erased, for a sector erase;
- any location inside an unprotected sector, for a chip erase.

When the timeout bit is seen set, the block reads once more before it gives up, because the completion bit can change in the same cycle as the timeout bit. The lower bits of a status byte are not trusted at the moment completion is seen. After a pass, the block issues one last read and returns that whole byte as the result. A read budget and a per-read response limit end a run that does not converge.

Top module: `status_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_req_o`, `done_o` and `pass_o` are low until a start is taken.
- R2: A `start_i` pulse taken while idle latches `addr_i`. Every read of that run presents this address on `rd_addr_o`. A `start_i` that arrives while a run is active is ignored.
- R3: At most one read is outstanding. `rd_req_o` stays high until a cycle with `rd_vld_i` high completes the read, and it is low in the next cycle. `rd_vld_i` is ignored while `rd_req_o` is low.
- R4: In a program run (`erase_i`=0), a status byte whose bit 7 equals `exp_bit_i` counts as completion.
- R5: In an erase run (`erase_i`=1), the expected value of bit 7 is 1, whatever `exp_bit_i` is.
- R6: A byte with bit 7 unequal to the expected value and bit 5 clear leads to another read of the same address.
- R7: A byte with bit 7 unequal to the expected value and bit 5 set leads to exactly one more read. If bit 7 of that byte matches, the run goes on toward pass. If it does not match, the run ends with fail.
- R8: After completion is seen, one further read is issued. The run then ends with pass, and `data_o` takes the full byte of that last read. `data_o` is left unchanged by a failed run.
- R9: If the first `MAX_POLLS` reads of a run are all mismatches with bit 5 clear, the run ends with fail after the last of them.
- R10: If `rd_req_o` stays high for `RSP_LIMIT` cycles without `rd_vld_i`, the run ends with fail and the request is withdrawn.
- R11: `done_o` is high for exactly one cycle per run. `pass_o` and `data_o` change only in the cycle in which `done_o` is high, and hold their values until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a polling run |
| erase_i | input | 1 | 1: erase run (expected bit 7 is 1); 0: program run |
| exp_bit_i | input | 1 | Expected bit 7 value in a program run |
| addr_i | input | AW | Address to poll |
| rd_req_o | output | 1 | Read request, held until it is answered |
| rd_addr_o | output | AW | Address of the read |
| rd_vld_i | input | 1 | Read response strobe |
| rd_data_i | input | DW | Status byte returned with `rd_vld_i` |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Verdict of the last run (1 = pass) |
| data_o | output | DW | Byte from the closing read of the last passing run |

## Verification
The bench builds the block with `AW`=16, `DW`=8, `MAX_POLLS`=6 and `RSP_LIMIT`=20. These small limits let directed runs reach the read-budget failure after six status reads. They also let the bench count the exact cycle at which the response-limit failure occurs, which is not practical with the default budgets. The status bits keep their default positions (bit 7 and bit 5), so the bench can write the status bytes as plain constants.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_FINAL = 2'd3
  } poll_state_t;

endpackage

// File: rtl/sp_status_eval.sv
// Decodes one returned status byte against the expected completion value.
module sp_status_eval #(
  parameter int DW       = 8,
  parameter int FLAG_BIT = 7,
  parameter int TMO_BIT  = 5
) (
  input  logic [DW-1:0] rd_byte_i,
  input  logic          exp_i,
  output logic          match_o,
  output logic          tmo_o
);

  assign match_o = (rd_byte_i[FLAG_BIT] == exp_i);
  assign tmo_o   = rd_byte_i[TMO_BIT];

endmodule

// File: rtl/sp_counter.sv
// Saturation-free budget counter; last_o flags the final allowed step.
module sp_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/sp_fsm.sv
// Polling sequencer: request pacing, verdict and result registers.
module sp_fsm
  import sp_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic          exp_bit_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          match_i,
  input  logic          tmo_i,
  input  logic          poll_last_i,
  input  logic          wait_last_i,
  output logic          exp_o,
  output logic          poll_clr_o,
  output logic          poll_inc_o,
  output logic          wait_clr_o,
  output logic          wait_inc_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] data_o
);

  poll_state_t   state_q, state_d;
  logic          req_q, req_d;
  logic          exp_q, exp_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          pass_q, pass_d;
  logic [DW-1:0] data_q, data_d;
  logic          accept;
  logic          ctx_en;
  logic          res_en;

  assign accept = req_q & rd_vld_i;

  // Wait counter runs only while a request is pending and unanswered.
  assign wait_clr_o = ~req_q | rd_vld_i;
  assign wait_inc_o = req_q & ~rd_vld_i;

  always_comb begin
    state_d    = state_q;
    req_d      = req_q;
    exp_d      = exp_q;
    addr_d     = addr_q;
    done_d     = 1'b0;
    pass_d     = pass_q;
    data_d     = data_q;
    poll_clr_o = 1'b0;
    poll_inc_o = 1'b0;

    if (state_q == ST_IDLE) begin
      req_d = 1'b0;
      if (start_i) begin
        state_d    = ST_POLL;
        exp_d      = erase_i ? 1'b1 : exp_bit_i;
        addr_d     = addr_i;
        req_d      = 1'b1;
        poll_clr_o = 1'b1;
      end
    end else if (accept) begin
      req_d = 1'b0;
      unique case (state_q)
        ST_POLL: begin
          if (match_i) begin
            state_d = ST_FINAL;
          end else if (tmo_i) begin
            state_d = ST_RECHK;
          end else if (poll_last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            pass_d  = 1'b0;
          end else begin
            poll_inc_o = 1'b1;
          end
        end
        ST_RECHK: begin
          if (match_i) begin
            state_d = ST_FINAL;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            pass_d  = 1'b0;
          end
        end
        ST_FINAL: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          pass_d  = 1'b1;
          data_d  = rd_data_i;
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end else if (req_q && wait_last_i) begin
      state_d = ST_IDLE;
      req_d   = 1'b0;
      done_d  = 1'b1;
      pass_d  = 1'b0;
    end else begin
      req_d = 1'b1;
    end
  end

  assign ctx_en = (state_q == ST_IDLE) & start_i;
  assign res_en = done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else if (ctx_en) begin
      exp_q  <= exp_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      data_q <= '0;
    end else if (res_en) begin
      pass_q <= pass_d;
      data_q <= data_d;
    end
  end

  assign exp_o     = exp_q;
  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign data_o    = data_q;

endmodule

// File: rtl/status_poll_ctrl.sv
module status_poll_ctrl #(
  parameter int AW        = 24,
  parameter int DW        = 8,
  parameter int FLAG_BIT  = DW - 1,
  parameter int TMO_BIT   = 5,
  parameter int MAX_POLLS = 4096,
  parameter int RSP_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic          exp_bit_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] data_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       exp_w;
  logic       match_w;
  logic       tmo_w;
  logic       poll_clr_w;
  logic       poll_inc_w;
  logic       poll_last_w;
  logic       wait_clr_w;
  logic       wait_inc_w;
  logic       wait_last_w;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  sp_status_eval #(
    .DW       (DW),
    .FLAG_BIT (FLAG_BIT),
    .TMO_BIT  (TMO_BIT)
  ) u_eval (
    .rd_byte_i (rd_data_i),
    .exp_i     (exp_w),
    .match_o   (match_w),
    .tmo_o     (tmo_w)
  );

  sp_counter #(.LIMIT(MAX_POLLS)) u_poll_budget (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (poll_clr_w),
    .inc_i  (poll_inc_w),
    .last_o (poll_last_w)
  );

  sp_counter #(.LIMIT(RSP_LIMIT)) u_rsp_wait (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (wait_clr_w),
    .inc_i  (wait_inc_w),
    .last_o (wait_last_w)
  );

  sp_fsm #(
    .AW (AW),
    .DW (DW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (start_i),
    .erase_i     (erase_i),
    .exp_bit_i   (exp_bit_i),
    .addr_i      (addr_i),
    .rd_vld_i    (rd_vld_i),
    .rd_data_i   (rd_data_i),
    .match_i     (match_w),
    .tmo_i       (tmo_w),
    .poll_last_i (poll_last_w),
    .wait_last_i (wait_last_w),
    .exp_o       (exp_w),
    .poll_clr_o  (poll_clr_w),
    .poll_inc_o  (poll_inc_w),
    .wait_clr_o  (wait_clr_w),
    .wait_inc_o  (wait_inc_w),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .data_o      (data_o)
  );

endmodule

// File: rtl/status_poll_ctrl_chk.sv
module status_poll_ctrl_chk #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_vld_i,
  input logic          done_o,
  input logic          pass_o,
  input logic [DW-1:0] data_o
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_vld_i && !done_o) |=> (rd_req_o || done_o)); // R3

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_vld_i) |=> !rd_req_o); // R3

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> $stable(rd_addr_o)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o); // R11

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pass_o)); // R11

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && pass_o) |-> $stable(data_o)); // R8

endmodule

bind status_poll_ctrl status_poll_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/status_poll_ctrl_bench.sv
module status_poll_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int DW         = 8;
  localparam int MAX_POLLS  = 6;
  localparam int RSP_LIMIT  = 20;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          erase_i;
  logic          exp_bit_i;
  logic [AW-1:0] addr_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_vld_i;
  logic [DW-1:0] rd_data_i;
  logic          done_o;
  logic          pass_o;
  logic [DW-1:0] data_o;

  int n_cmp;
  int n_bad;
  int n_reads;

  status_poll_ctrl #(
    .AW(AW), .DW(DW), .MAX_POLLS(MAX_POLLS), .RSP_LIMIT(RSP_LIMIT)
  ) u_status_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .exp_bit_i(exp_bit_i), .addr_i(addr_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .pass_o(pass_o), .data_o(data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic ers, input logic eb, input logic [AW-1:0] a);
    @(negedge clk);
    start_i = 1'b1; erase_i = ers; exp_bit_i = eb; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    n_reads = 0;
  endtask

  // Answer the next read; returns at the negedge after the response edge.
  task automatic serve(input logic [DW-1:0] d, input logic [AW-1:0] a);
    int w = 0;
    while (!rd_req_o && w < 50) begin
      @(negedge clk);
      w++;
    end
    chk("R2 read address", rd_addr_o, a);
    rd_vld_i = 1'b1; rd_data_i = d;
    @(negedge clk);
    rd_vld_i = 1'b0; rd_data_i = '0;
    n_reads++;
    chk("R3 request low after response", rd_req_o, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset request", rd_req_o, 1'b0);
    chk("R1 reset done", done_o, 1'b0);
    chk("R1 reset pass", pass_o, 1'b0);
  endtask

  task automatic t_prog_one_after_polls();
    launch(1'b0, 1'b1, 16'h1234);
    serve(8'h00, 16'h1234);                     // R6 keep polling
    serve(8'h13, 16'h1234);
    serve(8'h80, 16'h1234);                     // R4 match on bit 7
    chk("R8 no verdict before closing read", done_o, 1'b0);
    serve(8'hC3, 16'h1234);
    chk("R8 done after closing read", done_o, 1'b1);
    chk("R8 pass", pass_o, 1'b1);
    chk("R8 closing byte", data_o, 8'hC3);
    chk("R6 read count", n_reads, 4);
    @(negedge clk);
    chk("R11 done is one cycle", done_o, 1'b0);
    chk("R11 pass held", pass_o, 1'b1);
  endtask

  task automatic t_prog_zero_immediate();
    launch(1'b0, 1'b0, 16'h0042);
    serve(8'h7F, 16'h0042);                     // R4 bit 7 = 0 matches
    serve(8'h12, 16'h0042);
    chk("R4 pass with expected 0", pass_o, 1'b1);
    chk("R4 done", done_o, 1'b1);
    chk("R8 closing byte", data_o, 8'h12);
  endtask

  task automatic t_erase();
    launch(1'b1, 1'b0, 16'hBEEF);
    serve(8'h00, 16'hBEEF);                     // R5 0 is a mismatch in erase
    chk("R5 still polling", done_o, 1'b0);
    serve(8'h80, 16'hBEEF);
    serve(8'hFF, 16'hBEEF);
    chk("R5 erase pass", pass_o, 1'b1);
    chk("R5 read count", n_reads, 3);
    chk("R5 closing byte", data_o, 8'hFF);
  endtask

  task automatic t_recheck_pass();
    launch(1'b0, 1'b1, 16'h0100);
    serve(8'h20, 16'h0100);                     // R7 timeout bit set
    chk("R7 recheck pending", done_o, 1'b0);
    serve(8'hA0, 16'h0100);
    serve(8'h5A, 16'h0100);
    chk("R7 recheck match passes", pass_o, 1'b1);
    chk("R7 closing byte", data_o, 8'h5A);
  endtask

  task automatic t_recheck_fail();
    launch(1'b0, 1'b1, 16'h0200);
    serve(8'h20, 16'h0200);
    serve(8'h20, 16'h0200);
    chk("R7 recheck mismatch done", done_o, 1'b1);
    chk("R7 recheck mismatch fails", pass_o, 1'b0);
    chk("R8 data kept on fail", data_o, 8'h5A);
    @(negedge clk);
    chk("R7 no further read", rd_req_o, 1'b0);
  endtask

  task automatic t_budget();
    launch(1'b0, 1'b1, 16'h0300);
    for (int i = 0; i < MAX_POLLS - 1; i++) serve(8'h01, 16'h0300);
    chk("R9 no verdict before budget", done_o, 1'b0);
    serve(8'h01, 16'h0300);
    chk("R9 budget done", done_o, 1'b1);
    chk("R9 budget fail", pass_o, 1'b0);
    chk("R9 read count", n_reads, MAX_POLLS);
  endtask

  task automatic t_no_response();
    int cyc = 0;
    launch(1'b0, 1'b1, 16'h0400);
    chk("R10 request raised", rd_req_o, 1'b1);
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 timeout cycle", cyc, RSP_LIMIT);
    chk("R10 timeout fails", pass_o, 1'b0);
    chk("R10 request withdrawn", rd_req_o, 1'b0);
    rd_vld_i = 1'b1; rd_data_i = 8'h80;         // R3 stray response while idle
    @(negedge clk);
    rd_vld_i = 1'b0; rd_data_i = '0;
    @(negedge clk);
    chk("R3 stray response no done", done_o, 1'b0);
    chk("R3 stray response no request", rd_req_o, 1'b0);
    chk("R3 stray response verdict kept", pass_o, 1'b0);
  endtask

  task automatic t_start_while_busy();
    launch(1'b0, 1'b0, 16'h0500);
    start_i = 1'b1; erase_i = 1'b1; addr_i = 16'h0600;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy start keeps address", rd_addr_o, 16'h0500);
    serve(8'h00, 16'h0500);                     // matches only the first run
    serve(8'h3C, 16'h0500);
    chk("R2 busy start ignored", done_o, 1'b1);
    chk("R2 pass", pass_o, 1'b1);
    chk("R2 closing byte", data_o, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; n_reads = 0;
    rst_n = 1'b0; start_i = 1'b0; erase_i = 1'b0; exp_bit_i = 1'b0;
    addr_i = '0; rd_vld_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prog_one_after_polls();
    t_prog_zero_immediate();
    t_erase();
    t_recheck_pass();
    t_recheck_fail();
    t_budget();
    t_no_response();
    t_start_while_busy();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule